// File: doc/BRIEF.md
# Supply Guard: Brown-Out Reset with Re-Arm Lock

This block is the digital half of a power-on and brown-out reset circuit. Two analog comparators report whether the supply is above an upper threshold (about 1.7 V) and whether it is above a lower re-arm threshold (about 1.2 V). The block turns these two flags into an active-low reset for the rest of the chip.

A plain hysteresis detector oscillates on a battery whose voltage recovers once the load is removed. This block avoids that. After a brown-out has asserted reset, reset stays locked even if the supply climbs back over the upper threshold. The lock clears only after the supply has dropped below the re-arm threshold, as it does when the battery is removed. A later rise above the upper threshold then releases reset.

Both flags are asynchronous to the clock. Each one passes through a two-stage synchronizer and a stability filter, which acts on a new level only after it has held for `STABLE_CYC` consecutive clocks. A status output tells a lock-held reset apart from a reset caused by a low supply.

Top module: `supply_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `por_n` is 0 and `lock_hold` is 0.
- R2: From the power-up state, with `above_lo` already high, `por_n` rises exactly `STABLE_CYC`+5 clocks after `above_hi` rises. It is still 0 one clock earlier.
- R3: With `por_n` high, a fall of `above_hi` drives `por_n` to 0 exactly `STABLE_CYC`+4 clocks later. It is still 1 one clock earlier.
- R4: After a brown-out, if `above_hi` returns high without `above_lo` having gone low, `por_n` stays 0 and `lock_hold` reads 1.
- R5: `lock_hold` is 0 whenever the filtered `above_hi` is low, and is never 1 while `por_n` is 1.
- R6: A filtered low on `above_lo` clears the lock. The next settled rise of `above_hi` releases `por_n`.
- R7: A pulse on either flag that lasts fewer than `STABLE_CYC` clocks changes neither `por_n` nor `lock_hold`. This includes a short dip of `above_lo`, which does not re-arm the lock.
- R8: Under random sequences of settled supply zones (below re-arm, between thresholds, above upper), `por_n` and `lock_hold` follow the zone model given by R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the logic |
| above_hi | input | 1 | Asynchronous comparator flag: supply above the upper threshold |
| above_lo | input | 1 | Asynchronous comparator flag: supply above the re-arm threshold |
| por_n | output | 1 | Registered active-low reset output |
| lock_hold | output | 1 | Registered flag: reset is held by the lock while the supply is above the upper threshold |

## Verification
The assertions assume a physically consistent pair of flags: the filtered upper flag is never high while the filtered re-arm flag is low, because a supply cannot be above the upper threshold and below the lower one at once. The stimulus only ever applies three supply zones, and every zone change keeps that ordering. Glitches on the re-arm flag are applied only while the upper flag is low. The random zone holds always exceed the filter and pipeline latency, so every check samples a settled state.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_FLAGS   = 2;
  localparam int IDX_HI      = 0;
  localparam int IDX_LO      = 1;

  typedef struct packed {
    logic armed;
    logic caught;
    logic por_n;
  } lock_state_t;
endpackage

// File: rtl/sg_flag_filter.sv
module sg_flag_filter #(
  parameter int STAGES     = 2,
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic [STAGES-1:0] sync_q;
  logic              cand_q;
  logic [CW-1:0]     cnt_q;
  logic              clean_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q  <= 1'b0;
      cnt_q   <= '0;
      clean_q <= 1'b0;
    end else if (sync_q[STAGES-1] != cand_q) begin
      cand_q <= sync_q[STAGES-1];
      cnt_q  <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      clean_q <= cand_q;
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/sg_lock_core.sv
module sg_lock_core
  import supply_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hi_f,
  input  logic lo_f,
  output logic por_n,
  output logic lock_hold
);
  lock_state_t st_q, st_d;
  logic        lock_q, lock_d;
  logic        release_now;

  always_comb begin
    release_now  = hi_f & st_q.caught;
    st_d.por_n   = hi_f & (st_q.por_n | st_q.caught);
    st_d.armed   = release_now ? 1'b0 : (st_q.armed | ~lo_f);
    st_d.caught  = release_now ? 1'b0 : (st_q.caught | (st_q.armed & hi_f));
    lock_d       = ~st_d.por_n & hi_f & ~st_d.armed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
    end
  end

  assign por_n     = st_q.por_n;
  assign lock_hold = lock_q;
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic above_lo,
  output logic por_n,
  output logic lock_hold
);
  logic [NUM_FLAGS-1:0] raw_flags;
  logic [NUM_FLAGS-1:0] clean_flags;
  logic hi_f, lo_f;

  assign raw_flags[IDX_HI] = above_hi;
  assign raw_flags[IDX_LO] = above_lo;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
    sg_flag_filter #(
      .STAGES     (SYNC_STAGES),
      .STABLE_CYC (STABLE_CYC)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_flags[g]),
      .clean (clean_flags[g])
    );
  end

  assign hi_f = clean_flags[IDX_HI];
  assign lo_f = clean_flags[IDX_LO];

  sg_lock_core u_core (
    .clk       (clk),
    .rst       (rst),
    .hi_f      (hi_f),
    .lo_f      (lo_f),
    .por_n     (por_n),
    .lock_hold (lock_hold)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic clk,
  input logic rst,
  input logic hi_f,
  input logic lo_f,
  input logic por_n,
  input logic lock_hold
);
  AST_DROP_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_f) |=> !por_n); // R3
  AST_RELEASE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    por_n |-> $past(hi_f)); // R2
  AST_LOCK_IMPLIES_RESET: assert property (@(posedge clk) disable iff (rst)
    lock_hold |-> !por_n); // R5
  AST_LOCK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !hi_f |=> !lock_hold); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (lock_hold && lo_f) |=> !por_n); // R4
  AST_LOW_CLEARS_LOCK: assert property (@(posedge clk) disable iff (rst)
    !lo_f |=> !lock_hold); // R6
endmodule

bind supply_guard sg_checker u_sg_checker (
  .clk       (clk),
  .rst       (rst),
  .hi_f      (hi_f),
  .lo_f      (lo_f),
  .por_n     (por_n),
  .lock_hold (lock_hold)
);

// File: tb/tb_supply_guard.sv
module tb_supply_guard;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_hi = 1'b0;
  logic above_lo = 1'b0;
  logic por_n, lock_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit ref_armed = 1'b1;
  bit ref_up    = 1'b0;

  always #2.5 clk = ~clk;

  supply_guard #(.STABLE_CYC(N)) dut (
    .clk(clk), .rst(rst), .above_hi(above_hi), .above_lo(above_lo),
    .por_n(por_n), .lock_hold(lock_hold)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // zone 0: below re-arm, 1: between thresholds, 2: above upper
  task automatic set_zone(input int z);
    above_lo = (z >= 1);
    above_hi = (z == 2);
  endtask

  function automatic void model_zone(input int z);
    if (z == 0) begin ref_armed = 1'b1; ref_up = 1'b0; end
    else if (z == 1) ref_up = 1'b0;
    else if (ref_armed) begin ref_up = 1'b1; ref_armed = 1'b0; end
  endfunction

  function automatic logic exp_por(input int z);
    return (z == 2) && ref_up;
  endfunction

  function automatic logic exp_lock(input int z);
    return (z == 2) && !ref_up;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(3);
    chk("R1 por_n in reset", por_n, 1'b0);
    chk("R1 lock_hold in reset", lock_hold, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 por_n after reset", por_n, 1'b0);
    chk("R1 lock_hold after reset", lock_hold, 1'b0);
    step(N + 8);

    // R2: power-up release latency
    above_lo = 1'b1;
    step(N + 8);
    chk("R2 mid zone holds reset", por_n, 1'b0);
    chk("R5 mid zone not locked", lock_hold, 1'b0);
    above_hi = 1'b1;
    step(N + 4);
    chk("R2 one clock before release", por_n, 1'b0);
    step(1);
    chk("R2 release at N+5", por_n, 1'b1);
    chk("R5 not locked when released", lock_hold, 1'b0);
    step(10);

    // R3: brown-out latency
    above_hi = 1'b0;
    step(N + 3);
    chk("R3 one clock before assert", por_n, 1'b1);
    step(1);
    chk("R3 assert at N+4", por_n, 1'b0);
    step(10);
    chk("R5 no lock while hi low", lock_hold, 1'b0);

    // R4: recovery without re-arm stays locked
    above_hi = 1'b1;
    step(N + 10);
    chk("R4 por_n stays low", por_n, 1'b0);
    chk("R4 lock_hold set", lock_hold, 1'b1);

    // R7: short hi glitch while locked
    above_hi = 1'b0;
    step(N - 2);
    above_hi = 1'b1;
    step(N + 10);
    chk("R7 hi glitch keeps lock", lock_hold, 1'b1);
    chk("R7 hi glitch keeps reset", por_n, 1'b0);

    // R7: short lo dip does not re-arm
    above_hi = 1'b0;
    step(N + 10);
    above_lo = 1'b0;
    step(N - 1);
    above_lo = 1'b1;
    step(N + 10);
    above_hi = 1'b1;
    step(N + 10);
    chk("R7 lo glitch does not re-arm", por_n, 1'b0);
    chk("R7 lo glitch lock remains", lock_hold, 1'b1);

    // R6: real re-arm
    above_hi = 1'b0;
    step(N + 6);
    above_lo = 1'b0;
    step(N + 8);
    chk("R6 lock cleared below re-arm", lock_hold, 1'b0);
    above_lo = 1'b1;
    step(N + 8);
    above_hi = 1'b1;
    step(N + 10);
    chk("R6 release after re-arm", por_n, 1'b1);
    chk("R6 no lock after release", lock_hold, 1'b0);

    // R7: short hi dip while released
    above_hi = 1'b0;
    step(N - 1);
    above_hi = 1'b1;
    step(N + 10);
    chk("R7 hi glitch keeps released", por_n, 1'b1);

    // R8: random settled zones against model
    ref_armed = 1'b0;
    ref_up = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int z;
      z = int'($urandom_range(0, 2));
      set_zone(z);
      model_zone(z);
      step(N + 8 + int'($urandom_range(0, 40)));
      chk("R8 random por_n", por_n, exp_por(z));
      chk("R8 random lock_hold", lock_hold, exp_lock(z));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule